// File: doc/BRIEF.md
# Two-Level Priority Interrupt Sequencer

This block runs interrupt entry and return for a small processor core that serves two nested interrupt levels. Each clock edge it looks at the high- and low-priority request lines, the two per-level enable bits it holds, and the return strobe. When it accepts a request, it does four things in the same cycle. It pushes the resume address (`pc_in`) onto an 8-entry hardware return stack, copies the accumulator, status and bank-select values into one set of shadow registers, clears the enables for the level being served, and issues a one-cycle program-counter load to that level's fixed vector. A return pops the stack into the program counter and restores the enable pair that was saved on entry. A return with restore also presents the shadow copies for write-back.

The control is a three-state machine, with `level` encoding 0 = RUN, 1 = LOW and 2 = HIGH.
- Transitions into a handler:
  - RUN→HIGH and RUN→LOW are taken on an accepted request.
  - LOW→HIGH is taken on high-priority preemption.
  - HIGH→HIGH is taken on re-entry, after software has re-enabled the high level inside its own handler.
- Transitions on return (any state): the machine moves to the level of the handler that is still on the stack below the one being left. If that was the last stacked handler, or the stack is empty, it moves to RUN.

Software sets both enables at once through `cfg_wr`. Each stack entry holds the resume address, a high/low tag and the two enable bits as they were before entry.

Top module: `prio_irq_sequencer`

## Requirements
- R1: After reset, `pc_load`=0, `pc_target`=0x0000, both enables are 0, `level`=0, `restore_valid`=0, and both stack flags are 0.
- R2: When a high request is accepted on a clock edge, the next cycle shows `pc_load`=1 and `pc_target`=0x0008, both enables cleared, and `level`=2. `pc_load` is a one-cycle pulse.
- R3: When a low request is accepted, the next cycle shows `pc_load`=1, `pc_target`=0x0018, `lo_en`=0, `hi_en` unchanged, and `level`=1.
- R4: When high and low requests are both accepted-eligible on the same edge, the high level is served.
- R5: An enabled high request preempts a running low handler. A low request is never accepted while `level`=2, even if `lo_en` has been rewritten to 1.
- R6: A return loads `pc_target` with the `pc_in` value sampled at the matching entry, in last-in-first-out order.
- R7: A return from a stacked entry restores `hi_en`/`lo_en` to their values just before that entry. `level` becomes the level of the enclosing handler, or 0.
- R8: A return with `ret_fast`=1 gives `restore_valid`=1 for one cycle, with `wreg_out`/`status_out`/`bank_out` equal to the inputs at the most recent entry. A plain return leaves `restore_valid`=0.
- R9: A request whose enable is 0 causes no `pc_load` and no change of `level`.
- R10: A return on the same edge as a request wins. The request is served on a later edge only if it is still asserted and enabled.
- R11: `cfg_wr` loads `hi_en`/`lo_en` on the next cycle. An entry or a return on the same edge takes precedence and discards the write.
- R12: A push onto a full stack sets the sticky `stk_overflow` and discards the entry. The vector is still loaded.
- R13: A return on an empty stack sets the sticky `stk_underflow`, loads `pc_target`=0x0000, leaves the enables unchanged, and sets `level`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_in | input | 16 | Resume address to stack on entry |
| hi_req | input | 1 | High-priority request |
| lo_req | input | 1 | Low-priority request |
| cfg_wr | input | 1 | Write strobe for both enables |
| cfg_hi_en | input | 1 | High enable value to write |
| cfg_lo_en | input | 1 | Low enable value to write |
| ret_req | input | 1 | Return-from-interrupt strobe |
| ret_fast | input | 1 | With `ret_req`: also restore working registers |
| wreg_in | input | 8 | Current accumulator |
| status_in | input | 8 | Current status register |
| bank_in | input | 4 | Current bank select |
| pc_load | output | 1 | One-cycle program-counter load |
| pc_target | output | 16 | Address to load |
| hi_en | output | 1 | High-level enable |
| lo_en | output | 1 | Low-level enable |
| level | output | 2 | Level in service: 0 none, 1 low, 2 high |
| restore_valid | output | 1 | Shadow values to be written back |
| wreg_out | output | 8 | Shadow accumulator |
| status_out | output | 8 | Shadow status |
| bank_out | output | 4 | Shadow bank select |
| stk_overflow | output | 1 | Sticky stack overflow |
| stk_underflow | output | 1 | Sticky stack underflow |

## Verification
The overflow path is the hardest to reach. With only two levels, plain nesting never stacks more than two entries. The bench therefore re-enables the high level through `cfg_wr` after every high entry, so each new high request re-enters on top of the last, until nine entries have been pushed. It then checks that the first return gives the eighth address, not the ninth. The preemption case where a low handler's saved enables must come back after the nested high return is reached by a table sequence: a low entry, a high entry, an enable rewrite inside the high handler, and then two returns.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/irq_seq_arbiter.sv
module irq_seq_arbiter
    import irq_seq_pkg::*;
(
    input  logic       hi_req,
    input  logic       lo_req,
    input  logic       hi_en,
    input  logic       lo_en,
    input  logic       ret_req,
    input  seq_state_e state,
    output logic       take_hi,
    output logic       take_lo
);
    // Return outranks any request; high outranks low; low never nests in high.
    always_comb begin
        take_hi = !ret_req && hi_req && hi_en;
        take_lo = !ret_req && lo_req && lo_en && !take_hi && (state != ST_HIGH);
    end
endmodule

// File: rtl/irq_seq_stack.sv
module irq_seq_stack #(
    parameter int DEPTH   = 8,
    parameter int W       = 19,
    parameter int TAG_IDX = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top_q,
    output logic         below_tag,
    output logic         empty,
    output logic         single,
    output logic         overflow,
    output logic         underflow
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [CW-1:0] cnt;
    logic          full;
    logic [AW-1:0] top_idx;
    logic [AW-1:0] below_idx;
    logic [W-1:0]  below_q;

    always_comb begin
        full      = (cnt == CW'(DEPTH));
        empty     = (cnt == '0);
        single    = (cnt == CW'(1));
        top_idx   = AW'(cnt - CW'(1));
        below_idx = AW'(cnt - CW'(2));
        top_q     = empty ? '0 : mem[top_idx];
        below_q   = (cnt < CW'(2)) ? '0 : mem[below_idx];
        below_tag = below_q[TAG_IDX];
    end

    always_ff @(posedge clk) begin
        if (push && !full) mem[AW'(cnt)] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else if (push) begin
            if (full) overflow <= 1'b1;
            else      cnt      <= cnt + CW'(1);
        end else if (pop) begin
            if (empty) underflow <= 1'b1;
            else       cnt       <= cnt - CW'(1);
        end
    end

    a_r12_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);
    a_r13_unf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |=> underflow);
    a_r12_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));
    a_r12_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (cnt == CW'(DEPTH)));
endmodule

// File: rtl/irq_seq_shadow.sv
module irq_seq_shadow #(
    parameter int DW = 8,
    parameter int BW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture,
    input  logic [DW-1:0] wreg_in,
    input  logic [DW-1:0] status_in,
    input  logic [BW-1:0] bank_in,
    output logic [DW-1:0] wreg_q,
    output logic [DW-1:0] status_q,
    output logic [BW-1:0] bank_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wreg_q   <= '0;
            status_q <= '0;
            bank_q   <= '0;
        end else if (capture) begin
            wreg_q   <= wreg_in;
            status_q <= status_in;
            bank_q   <= bank_in;
        end
    end

    a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> ($stable(wreg_q) && $stable(status_q) && $stable(bank_q)));
endmodule

// File: rtl/prio_irq_sequencer.sv
module prio_irq_sequencer
    import irq_seq_pkg::*;
#(
    parameter int          PC_W    = 16,
    parameter int          DW      = 8,
    parameter int          BW      = 4,
    parameter int          DEPTH   = 8,
    parameter logic [15:0] RST_VEC = 16'h0000,
    parameter logic [15:0] HI_VEC  = 16'h0008,
    parameter logic [15:0] LO_VEC  = 16'h0018
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pc_in,
    input  logic            hi_req,
    input  logic            lo_req,
    input  logic            cfg_wr,
    input  logic            cfg_hi_en,
    input  logic            cfg_lo_en,
    input  logic            ret_req,
    input  logic            ret_fast,
    input  logic [DW-1:0]   wreg_in,
    input  logic [DW-1:0]   status_in,
    input  logic [BW-1:0]   bank_in,
    output logic            pc_load,
    output logic [PC_W-1:0] pc_target,
    output logic            hi_en,
    output logic            lo_en,
    output logic [1:0]      level,
    output logic            restore_valid,
    output logic [DW-1:0]   wreg_out,
    output logic [DW-1:0]   status_out,
    output logic [BW-1:0]   bank_out,
    output logic            stk_overflow,
    output logic            stk_underflow
);
    // Stack entry: {saved hi_en, saved lo_en, high tag, resume address}
    localparam int EW     = PC_W + 3;
    localparam int TAG_B  = PC_W;
    localparam int SLO_B  = PC_W + 1;
    localparam int SHI_B  = PC_W + 2;
    localparam logic [PC_W-1:0] V_RST = PC_W'(RST_VEC);
    localparam logic [PC_W-1:0] V_HI  = PC_W'(HI_VEC);
    localparam logic [PC_W-1:0] V_LO  = PC_W'(LO_VEC);

    seq_state_e    state, state_nxt, ret_state;
    logic          take_hi, take_lo, push;
    logic [EW-1:0] push_entry, top_q;
    logic          below_tag, stk_empty, stk_single;

    irq_seq_arbiter u_arb (
        .hi_req  (hi_req),
        .lo_req  (lo_req),
        .hi_en   (hi_en),
        .lo_en   (lo_en),
        .ret_req (ret_req),
        .state   (state),
        .take_hi (take_hi),
        .take_lo (take_lo)
    );

    assign push       = take_hi || take_lo;
    assign push_entry = {hi_en, lo_en, take_hi, pc_in};

    irq_seq_stack #(.DEPTH(DEPTH), .W(EW), .TAG_IDX(TAG_B)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .pop       (ret_req),
        .din       (push_entry),
        .top_q     (top_q),
        .below_tag (below_tag),
        .empty     (stk_empty),
        .single    (stk_single),
        .overflow  (stk_overflow),
        .underflow (stk_underflow)
    );

    irq_seq_shadow #(.DW(DW), .BW(BW)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (push),
        .wreg_in   (wreg_in),
        .status_in (status_in),
        .bank_in   (bank_in),
        .wreg_q    (wreg_out),
        .status_q  (status_out),
        .bank_q    (bank_out)
    );

    // Level resumed after a return: the handler still stacked beneath.
    always_comb begin
        if (stk_empty || stk_single) ret_state = ST_RUN;
        else                         ret_state = below_tag ? ST_HIGH : ST_LOW;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_RUN, ST_LOW: begin
                if (take_hi)      state_nxt = ST_HIGH;
                else if (take_lo) state_nxt = ST_LOW;
                else if (ret_req) state_nxt = ret_state;
            end
            ST_HIGH: begin
                if (take_hi)      state_nxt = ST_HIGH;
                else if (ret_req) state_nxt = ret_state;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nxt;
    end

    assign level = state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_load       <= 1'b0;
            pc_target     <= V_RST;
            hi_en         <= 1'b0;
            lo_en         <= 1'b0;
            restore_valid <= 1'b0;
        end else begin
            pc_load       <= 1'b0;
            restore_valid <= 1'b0;
            if (take_hi) begin
                pc_load   <= 1'b1;
                pc_target <= V_HI;
                hi_en     <= 1'b0;
                lo_en     <= 1'b0;
            end else if (take_lo) begin
                pc_load   <= 1'b1;
                pc_target <= V_LO;
                lo_en     <= 1'b0;
            end else if (ret_req) begin
                pc_load       <= 1'b1;
                restore_valid <= ret_fast;
                if (stk_empty) begin
                    pc_target <= V_RST;
                end else begin
                    pc_target <= top_q[PC_W-1:0];
                    hi_en     <= top_q[SHI_B];
                    lo_en     <= top_q[SLO_B];
                end
            end else if (cfg_wr) begin
                hi_en <= cfg_hi_en;
                lo_en <= cfg_lo_en;
            end
        end
    end

    a_r2_hi_entry: assert property (@(posedge clk) disable iff (!rst_n)
        take_hi |=> (pc_load && pc_target == V_HI && !hi_en && !lo_en && level == 2'd2));
    a_r3_lo_entry: assert property (@(posedge clk) disable iff (!rst_n)
        take_lo |=> (pc_load && pc_target == V_LO && !lo_en && hi_en == $past(hi_en)));
    a_r4_one_take: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({take_hi, take_lo}));
    a_r5_no_low_in_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HIGH) |-> !take_lo);
    a_r9_no_idle_load: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_req || lo_req || ret_req) |=> !pc_load);
    a_r10_ret_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ret_req |-> !(take_hi || take_lo));
    a_r13_empty_ret: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && stk_empty) |=> (stk_underflow && pc_target == V_RST && level == 2'd0));
endmodule

// File: tb/test_prio_irq_sequencer.sv
`timescale 1ns/1ps
module test_prio_irq_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] pc_in = '0;
    logic        hi_req = 0, lo_req = 0, cfg_wr = 0, cfg_hi_en = 0, cfg_lo_en = 0;
    logic        ret_req = 0, ret_fast = 0;
    logic [7:0]  wreg_in = '0, status_in = '0;
    logic [3:0]  bank_in = '0;
    logic        pc_load, hi_en, lo_en, restore_valid, stk_overflow, stk_underflow;
    logic [15:0] pc_target;
    logic [1:0]  level;
    logic [7:0]  wreg_out, status_out;
    logic [3:0]  bank_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    prio_irq_sequencer i_prio_irq_sequencer (
        .clk(clk), .rst_n(rst_n), .pc_in(pc_in), .hi_req(hi_req), .lo_req(lo_req),
        .cfg_wr(cfg_wr), .cfg_hi_en(cfg_hi_en), .cfg_lo_en(cfg_lo_en),
        .ret_req(ret_req), .ret_fast(ret_fast), .wreg_in(wreg_in),
        .status_in(status_in), .bank_in(bank_in), .pc_load(pc_load),
        .pc_target(pc_target), .hi_en(hi_en), .lo_en(lo_en), .level(level),
        .restore_valid(restore_valid), .wreg_out(wreg_out), .status_out(status_out),
        .bank_out(bank_out), .stk_overflow(stk_overflow), .stk_underflow(stk_underflow)
    );

    typedef struct packed {
        logic [7:0]  rq;
        logic        hi, lo, ret, fast, cfg, chi, clo;
        logic [15:0] pc;
        logic        e_load;
        logic [15:0] e_tgt;
        logic        e_hi, e_lo;
        logic [1:0]  e_lvl;
        logic        e_rv;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{8'd11, 0,0,0,0,1,1,1, 16'h0000, 0,16'h0000, 1,1, 2'd0, 0}, // R11 enable both
        '{8'd3,  0,1,0,0,0,0,0, 16'h0100, 1,16'h0018, 1,0, 2'd1, 0}, // R3 low entry
        '{8'd9,  0,1,0,0,0,0,0, 16'h0101, 0,16'h0000, 1,0, 2'd1, 0}, // R9 low disabled
        '{8'd5,  1,0,0,0,0,0,0, 16'h0105, 1,16'h0008, 0,0, 2'd2, 0}, // R5 preempt
        '{8'd11, 0,0,0,0,1,0,1, 16'h0000, 0,16'h0000, 0,1, 2'd2, 0}, // R11 rewrite in high
        '{8'd5,  0,1,0,0,0,0,0, 16'h0200, 0,16'h0000, 0,1, 2'd2, 0}, // R5 low blocked in high
        '{8'd7,  0,0,1,0,0,0,0, 16'h0000, 1,16'h0105, 1,0, 2'd1, 0}, // R7 R6 back to low
        '{8'd8,  0,0,1,1,0,0,0, 16'h0000, 1,16'h0100, 1,1, 2'd0, 1}, // R8 R6 fast return
        '{8'd4,  1,1,0,0,0,0,0, 16'h0300, 1,16'h0008, 0,0, 2'd2, 0}, // R4 high wins
        '{8'd10, 0,1,1,0,0,0,0, 16'h0310, 1,16'h0300, 1,1, 2'd0, 0}, // R10 return first
        '{8'd10, 0,1,0,0,0,0,0, 16'h0301, 1,16'h0018, 1,0, 2'd1, 0}, // R10 low served later
        '{8'd11, 0,0,1,0,1,0,0, 16'h0000, 1,16'h0301, 1,1, 2'd0, 0}, // R11 write lost to return
        '{8'd13, 0,0,1,0,0,0,0, 16'h0000, 1,16'h0000, 1,1, 2'd0, 0}, // R13 empty return
        '{8'd2,  0,0,0,0,0,0,0, 16'h0000, 0,16'h0000, 1,1, 2'd0, 0}  // R2 load is a pulse
    };

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        hi_req = 0; lo_req = 0; ret_req = 0; ret_fast = 0; cfg_wr = 0;
        cfg_hi_en = 0; cfg_lo_en = 0;
    endtask

    task automatic do_reset();
        idle_inputs();
        rst_n = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    task automatic check_reset();
        chk(pc_load == 0,       "R1 pc_load",       32'(pc_load), 0);
        chk(pc_target == 0,     "R1 pc_target",     32'(pc_target), 0);
        chk({hi_en, lo_en} == 0,"R1 enables",       32'({hi_en, lo_en}), 0);
        chk(level == 0,         "R1 level",         32'(level), 0);
        chk(restore_valid == 0, "R1 restore_valid", 32'(restore_valid), 0);
        chk({stk_overflow, stk_underflow} == 0, "R1 stack flags",
            32'({stk_overflow, stk_underflow}), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        do_reset();
        check_reset();

        // Table walk: drive at negedge, sample outputs at the following negedge.
        for (int i = 0; i < NV; i++) begin
            hi_req = VEC[i].hi; lo_req = VEC[i].lo; ret_req = VEC[i].ret;
            ret_fast = VEC[i].fast; cfg_wr = VEC[i].cfg;
            cfg_hi_en = VEC[i].chi; cfg_lo_en = VEC[i].clo;
            pc_in = VEC[i].pc; wreg_in = VEC[i].pc[7:0];
            status_in = VEC[i].pc[15:8]; bank_in = VEC[i].pc[3:0];
            @(negedge clk);
            chk(pc_load == VEC[i].e_load, $sformatf("R%0d row %0d pc_load", VEC[i].rq, i),
                32'(pc_load), 32'(VEC[i].e_load));
            if (VEC[i].e_load)
                chk(pc_target == VEC[i].e_tgt, $sformatf("R%0d row %0d pc_target", VEC[i].rq, i),
                    32'(pc_target), 32'(VEC[i].e_tgt));
            chk({hi_en, lo_en} == {VEC[i].e_hi, VEC[i].e_lo},
                $sformatf("R%0d row %0d enables", VEC[i].rq, i),
                32'({hi_en, lo_en}), 32'({VEC[i].e_hi, VEC[i].e_lo}));
            chk(level == VEC[i].e_lvl, $sformatf("R%0d row %0d level", VEC[i].rq, i),
                32'(level), 32'(VEC[i].e_lvl));
            chk(restore_valid == VEC[i].e_rv, $sformatf("R%0d row %0d restore_valid", VEC[i].rq, i),
                32'(restore_valid), 32'(VEC[i].e_rv));
        end
        idle_inputs();
        chk(stk_underflow == 1, "R13 underflow set", 32'(stk_underflow), 1);
        chk(stk_overflow == 0,  "R12 no overflow yet", 32'(stk_overflow), 0);

        // R8: shadow contents captured at entry come back on fast return.
        hi_req = 1; pc_in = 16'h0400; wreg_in = 8'hA5; status_in = 8'h3C; bank_in = 4'h7;
        @(negedge clk);
        chk(pc_load && pc_target == 16'h0008, "R2 high entry vector", 32'(pc_target), 32'h8);
        hi_req = 0; wreg_in = 8'h00; status_in = 8'hFF; bank_in = 4'h0;
        ret_req = 1; ret_fast = 1;
        @(negedge clk);
        idle_inputs();
        chk(restore_valid == 1, "R8 restore_valid", 32'(restore_valid), 1);
        chk(wreg_out == 8'hA5,   "R8 wreg_out",   32'(wreg_out), 32'hA5);
        chk(status_out == 8'h3C, "R8 status_out", 32'(status_out), 32'h3C);
        chk(bank_out == 4'h7,    "R8 bank_out",   32'(bank_out), 32'h7);
        chk(pc_target == 16'h0400, "R6 resume address", 32'(pc_target), 32'h400);
        @(negedge clk);
        chk(restore_valid == 0, "R8 restore_valid pulse", 32'(restore_valid), 0);

        // R9: high request with high disabled.
        cfg_wr = 1; cfg_hi_en = 0; cfg_lo_en = 0;
        @(negedge clk);
        idle_inputs();
        hi_req = 1;
        @(negedge clk);
        idle_inputs();
        chk(pc_load == 0 && level == 0, "R9 disabled high ignored", 32'({pc_load, level}), 0);

        // R12: re-entry of the high level nine times overflows an 8-deep stack.
        do_reset();
        check_reset();
        cfg_wr = 1; cfg_hi_en = 1; cfg_lo_en = 0;
        @(negedge clk);
        for (int k = 0; k < 9; k++) begin
            idle_inputs();
            hi_req = 1; pc_in = 16'h1000 + 16'(k);
            @(negedge clk);
            chk(pc_load && pc_target == 16'h0008, $sformatf("R12 entry %0d vector", k),
                32'(pc_target), 32'h8);
            if (k == 7) chk(stk_overflow == 0, "R12 overflow after 8", 32'(stk_overflow), 0);
            if (k == 8) chk(stk_overflow == 1, "R12 overflow after 9", 32'(stk_overflow), 1);
            idle_inputs();
            cfg_wr = 1; cfg_hi_en = 1; cfg_lo_en = 0;
            @(negedge clk);
        end
        idle_inputs();
        ret_req = 1;
        @(negedge clk);
        idle_inputs();
        chk(pc_target == 16'h1007, "R12 ninth entry discarded", 32'(pc_target), 32'h1007);
        chk(level == 2, "R7 level after nested return", 32'(level), 2);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule